// File: doc/BRIEF.md
# Dual-Clock Bidirectional Four-Stage Shift Register

This block holds a short word in a row of flip-flops and changes it in one of three ways: it loads all stages at once from a parallel input, it shifts toward the last stage with a serial bit entering the first stage, or it shifts toward the first stage. The third way needs no logic of its own: the board ties each stage output back to the parallel input of the stage before it and applies the new serial bit at the last parallel input, so a shift toward the first stage is simply a load. Two external strobe lines trigger the work. The shift strobe acts only while the mode line is low. The load strobe acts only while the mode line is high. Each one acts on its high-to-low transition.

The whole block runs on one fast system clock, so it stays fully synchronous. The two strobe lines and the mode line each pass through a two-flop synchronizer. A control unit looks for falling edges on the synchronized strobes and qualifies each one with the synchronized mode level from the same sample. It then sends a one-cycle strobe to the datapath, which updates the stage registers on the next system clock edge. One strobe line can drive both strobe inputs, and the mode line then picks the operation. A build-time switch can route the feedback inside the block instead; it is off by default.

Top module: `dual_clk_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all bits of `q` become 0.
- R2: A falling edge on `loadClk` while `modeSel` is 1 copies `parIn` into `q`, with `parIn[i]` going to `q[i]`. Each such edge produces exactly one update.
- R3: A falling edge on `shiftClk` while `modeSel` is 0 shifts toward the last stage. `q[0]` takes `serIn` and `q[i]` takes the old `q[i-1]`.
- R4: While `modeSel` is 1, `serIn` has no effect on any load result.
- R5: When `parIn` is driven as {new serial bit, `q[3]`, `q[2]`, `q[1]`}, a load edge shifts the word toward the first stage. The new bit lands in `q[3]`.
- R6: A falling edge on `loadClk` while `modeSel` is 0 leaves `q` unchanged. A falling edge on `shiftClk` while `modeSel` is 1 also leaves `q` unchanged.
- R7: A rising or falling change of `modeSel` never alters `q`, whether the strobe lines are high or low.
- R8: Rising edges on `shiftClk` or `loadClk` never alter `q`.
- R9: When `shiftClk` and `loadClk` are driven by the same signal, a falling edge shifts if `modeSel` is 0 and loads if it is 1.
- R10: After a strobe input falls between two `clk` edges, `q` keeps its old value through the second following rising edge of `clk`. It shows the new value after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shiftClk | input | 1 | Asynchronous strobe; its falling edge shifts toward the last stage when mode is 0 |
| loadClk | input | 1 | Asynchronous strobe; its falling edge loads `parIn` when mode is 1 |
| modeSel | input | 1 | Asynchronous mode line: 0 selects shift, 1 selects load |
| serIn | input | 1 | Serial bit that enters `q[0]` on a shift |
| parIn | input | 4 | Parallel load word; bit i goes to stage i |
| q | output | 4 | Stage outputs; `q[0]` is the first stage and `q[3]` the last |

## Verification
A wrong stage value never repairs itself. It stays on `q` and moves along one position on each later shift, so it shows up at the ports no later than the next check, and the bench compares every operation with its own model. A stray or missing update strobe gives an off-by-one word or a change where none is expected. The bench samples `q` one system cycle before and one cycle after the expected update cycle, so an update in the wrong cycle or a lost edge is seen within three cycles of the stimulus. Mode toggles and rising strobe edges are each followed by a check of `q` before the next operation. Any change they cause is therefore caught at once.

// File: rtl/dual_clk_shift_pkg.sv
package dual_clk_shift_pkg;

  typedef struct packed {
    logic doShiftRight;
    logic doLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import dual_clk_shift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftClkIn,
  input  logic         loadClkIn,
  input  logic         modeIn,
  output ctrlStrobes_t strobes
);

  logic [2:0] syncVec;
  logic       shiftSync, loadSync, modeSync;
  logic       shiftPrev, loadPrev;
  logic       shiftFall, loadFall;

  bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({modeIn, loadClkIn, shiftClkIn}),
    .syncOut (syncVec)
  );

  assign shiftSync = syncVec[0];
  assign loadSync  = syncVec[1];
  assign modeSync  = syncVec[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftPrev <= 1'b0;
      loadPrev  <= 1'b0;
    end else begin
      shiftPrev <= shiftSync;
      loadPrev  <= loadSync;
    end
  end

  assign shiftFall = shiftPrev & ~shiftSync;
  assign loadFall  = loadPrev  & ~loadSync;

  always_comb begin
    strobes              = '0;
    strobes.doShiftRight = shiftFall & ~modeSync;
    strobes.doLoad       = loadFall  &  modeSync;
  end

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.doShiftRight, strobes.doLoad}));

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doLoad |=> !strobes.doLoad);

  // R3
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doShiftRight |=> !strobes.doShiftRight);

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import dual_clk_shift_pkg::*;
#(
  parameter int WIDTH         = 4,
  parameter bit INTERNAL_LEFT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] loadSrc;
  logic [WIDTH-1:0] shiftSrc;

  for (genvar i = 0; i < WIDTH; i++) begin : g_src
    if (i == 0) begin : g_first
      assign shiftSrc[i] = serIn;
    end else begin : g_rest
      assign shiftSrc[i] = q[i-1];
    end
    if (INTERNAL_LEFT && i < LAST) begin : g_loop
      assign loadSrc[i] = q[i+1];
    end else begin : g_ext
      assign loadSrc[i] = parIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       q <= '0;
    else if (strobes.doLoad)       q <= loadSrc;
    else if (strobes.doShiftRight) q <= shiftSrc;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobes.doLoad || strobes.doShiftRight) |=> $stable(q));

  // R3
  shift_right_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doShiftRight |=>
      (q[0] == $past(serIn)) && (q[LAST:1] == $past(q[LAST-1:0])));

  if (!INTERNAL_LEFT) begin : g_load_chk
    // R2
    parallel_load_chk: assert property (@(posedge clk) disable iff (rst)
      strobes.doLoad |=> (q == $past(parIn)));
  end

endmodule

// File: rtl/dual_clk_shift_reg.sv
module dual_clk_shift_reg
  import dual_clk_shift_pkg::*;
#(
  parameter int WIDTH         = 4,
  parameter int SYNC_STAGES   = 2,
  parameter bit INTERNAL_LEFT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftClk,
  input  logic             loadClk,
  input  logic             modeSel,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q
);

  ctrlStrobes_t strobes;

  shift_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shiftClkIn (shiftClk),
    .loadClkIn  (loadClk),
    .modeIn     (modeSel),
    .strobes    (strobes)
  );

  shift_datapath #(.WIDTH(WIDTH), .INTERNAL_LEFT(INTERNAL_LEFT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .serIn   (serIn),
    .parIn   (parIn),
    .q       (q)
  );

endmodule

// File: tb/dual_clk_shift_reg_tb.sv
`timescale 1ns/1ps
module dual_clk_shift_reg_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shiftClk = 1'b1;
  logic       loadClk = 1'b1;
  logic       modeSel = 1'b0;
  logic       serIn = 1'b0;
  logic [3:0] parIn = 4'h0;
  logic [3:0] q;

  logic [3:0] expQ = 4'h0;
  int errs = 0;
  int checks = 0;
  bit tied = 1'b0;

  always #2.5 clk = ~clk;

  dual_clk_shift_reg u_dut (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .loadClk(loadClk),
    .modeSel(modeSel), .serIn(serIn), .parIn(parIn), .q(q)
  );

  function automatic logic [3:0] modelRight(logic [3:0] cur, logic s);
    return {cur[2:0], s};
  endfunction

  function automatic logic [3:0] modelLeft(logic [3:0] cur, logic s);
    return {s, cur[3:1]};
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    checks++;
    if (q !== exp) begin
      errs++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  // Drive strobe and mode levels at a falling clk edge, then check q
  // before (R10) and after the expected update cycle.
  task automatic step(logic nShift, logic nLoad, logic nMode, string req);
    logic [3:0] nxt;
    logic fallS, fallL;
    nxt   = expQ;
    fallS = shiftClk && !nShift;
    fallL = loadClk && !nLoad;
    if (fallS && !nMode) nxt = modelRight(expQ, serIn);
    if (fallL && nMode)  nxt = parIn;
    @(negedge clk);
    shiftClk = nShift;
    loadClk  = nLoad;
    modeSel  = nMode;
    @(negedge clk);
    @(negedge clk);
    chk({req, " R10 before update"}, expQ);
    @(negedge clk);
    expQ = nxt;
    chk(req, expQ);
  endtask

  task automatic raiseBoth(string req);
    step(1'b1, 1'b1, modeSel, req);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", 4'h0);

    // Directed load
    parIn = 4'b1010; serIn = 1'b1;
    step(1'b1, 1'b1, 1'b1, "R7 mode rise, strobes high");
    step(1'b1, 1'b0, 1'b1, "R2 load 1010");
    raiseBoth("R8 load strobe rise");
    // Serial ignored during load
    parIn = 4'b0101; serIn = 1'b1;
    step(1'b1, 1'b0, 1'b1, "R4 load with serIn=1");
    raiseBoth("R8 rise");
    // Wrong strobe in each mode
    serIn = 1'b1;
    step(1'b0, 1'b1, 1'b1, "R6 shift strobe in load mode");
    raiseBoth("R8 rise");
    step(1'b1, 1'b1, 1'b0, "R7 mode fall, strobes high");
    parIn = 4'b1111;
    step(1'b1, 1'b0, 1'b0, "R6 load strobe in shift mode");
    raiseBoth("R8 rise");
    // Multi-step right shift
    for (int k = 0; k < 5; k++) begin
      serIn = k[0];
      step(1'b0, 1'b1, 1'b0, "R3 shift right");
      raiseBoth("R8 shift strobe rise");
    end
    // Mode toggle with strobes low
    step(1'b0, 1'b0, 1'b0, "R3 lower both in shift mode");
    step(1'b0, 1'b0, 1'b1, "R7 mode rise, strobes low");
    step(1'b0, 1'b0, 1'b0, "R7 mode fall, strobes low");
    raiseBoth("R8 rise both");
    // Left shift via external feedback
    step(1'b1, 1'b1, 1'b1, "R7 mode rise");
    for (int k = 0; k < 4; k++) begin
      logic s;
      s = (k == 1 || k == 2);
      @(negedge clk);
      parIn = {s, q[3:1]};
      serIn = ~s;
      step(1'b1, 1'b0, 1'b1, "R5 shift left external");
      chk("R5 left model", modelLeft(modelLeft(4'h0, 1'b0), 1'b0) | expQ);
      raiseBoth("R8 rise");
    end

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      serIn = 1'($urandom);
      parIn = 4'($urandom);
      case (op)
        0: begin
          if (modeSel) step(1'b1, 1'b1, 1'b0, "R7 random mode change");
          step(1'b0, 1'b1, 1'b0, "R3 random shift right");
        end
        1: begin
          if (!modeSel) step(1'b1, 1'b1, 1'b1, "R7 random mode change");
          step(1'b1, 1'b0, 1'b1, "R2 random load");
        end
        2: begin
          logic s;
          if (!modeSel) step(1'b1, 1'b1, 1'b1, "R7 random mode change");
          s = 1'($urandom);
          @(negedge clk);
          parIn = {s, q[3:1]};
          begin
            logic [3:0] want;
            want = modelLeft(expQ, s);
            step(1'b1, 1'b0, 1'b1, "R5 random shift left");
            chk("R5 random left model", want);
          end
        end
        3: begin
          if (modeSel) step(1'b0, 1'b1, 1'b1, "R6 random wrong strobe");
          else         step(1'b1, 1'b0, 1'b0, "R6 random wrong strobe");
        end
        4: begin
          logic lv;
          lv = 1'($urandom);
          step(lv, lv, modeSel, "R7 random strobe level");
          step(lv, lv, ~modeSel, "R7 random mode toggle");
        end
        default: begin
          logic m;
          m = 1'($urandom);
          step(1'b1, 1'b1, m, "R7 random mode set");
          step(1'b0, 1'b0, m, "R9 random tied strobes");
        end
      endcase
      raiseBoth("R8 random rise");
    end

    // Reset mid-run
    parIn = 4'b1001;
    step(1'b1, 1'b1, 1'b1, "R7 mode set");
    step(1'b1, 1'b0, 1'b1, "R2 load before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expQ = 4'h0;
    chk("R1 reset mid-run", expQ);
    rst = 1'b0;
    raiseBoth("R8 rise after reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule